// File: doc/BRIEF.md
# Paged DMA Address and Count Generator

This block is the per-transfer engine that sits behind a DMA channel's programming registers. It joins a page register with a 16-bit offset counter to produce a 24-bit physical byte address for the current transfer. On every accepted step it moves the offset by one and takes one off the remaining transfer count. It flags the final transfer with a single-cycle terminal-count pulse.

Two transfer widths are supported. In byte mode every step addresses one byte inside a 64 KB page. In word mode every step addresses one 16-bit word inside a 128 KB page, and both byte lanes are enabled. The offset counter never carries into or borrows from the page. An address therefore wraps inside its page instead of crossing a boundary.

The width can come from the `wide_mode` pin, which is sampled when the registers are loaded, or a parameter can fix it. Bus timing and data movement are handled elsewhere. Every pin is plain control or status, and the block has no streaming interface.

Top module: `dma_pg_gen`

## Requirements
- R1: In byte mode, `phys_addr[23:16]` equals the working page and `phys_addr[15:0]` equals `cur_addr`.
- R2: In word mode, `phys_addr[23:17]` equals working page bits 7:1, `phys_addr[16:1]` equals `cur_addr`, and `phys_addr[0]` is 0. Page bit 0 has no effect on the address.
- R3: The offset wraps inside the page: incrementing from 0xFFFF gives 0x0000, decrementing from 0x0000 gives 0xFFFF, and the page bits of `phys_addr` stay unchanged in both cases.
- R4: Each accepted step changes `cur_addr` by +1 when `dec` is 0 and by -1 when `dec` is 1, with the value visible after the clock edge.
- R5: Each accepted step lowers `cur_count` by one. A loaded count of N allows exactly N+1 accepted steps, and the last of these takes the count from 0x0000 to 0xFFFF.
- R6: `tc` is high, combinationally, only in a cycle where `step` is high, `load` is low, the channel is armed and `cur_count` is 0x0000.
- R7: After the terminal step the channel is disarmed. Further steps leave `cur_addr` and `cur_count` unchanged and keep `tc` low until the next load.
- R8: `load` copies `ld_page`, `ld_addr` and `ld_count` into the working registers and arms the channel. When `load` and `step` are high in the same cycle, the load wins and no step is taken.
- R9: `byte_en` is 2'b11 in word mode. In byte mode it is 2'b01 when `cur_addr[0]` is 0 and 2'b10 when it is 1.
- R10: With `MODE_SEL`=0, the width is taken from `wide_mode` at load (1 = word) and holds until the next load. `MODE_SEL`=1 forces byte mode and `MODE_SEL`=2 forces word mode.
- R11: After reset the channel is disarmed, `cur_addr`, `cur_count` and `phys_addr` are 0, the width is byte, and `tc` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Copy the programmed values into the working registers and arm the channel |
| ld_page | input | 8 | Programmed page |
| ld_addr | input | 16 | Programmed start offset |
| ld_count | input | 16 | Programmed transfer count minus one |
| wide_mode | input | 1 | Width request sampled at load: 1 = word, 0 = byte |
| dec | input | 1 | Offset direction: 0 = increment, 1 = decrement |
| step | input | 1 | One transfer cycle completes this clock |
| phys_addr | output | 24 | Physical address of the current transfer |
| byte_en | output | 2 | Byte-lane enables for the current transfer |
| cur_addr | output | 16 | Working offset counter |
| cur_count | output | 16 | Working remaining count |
| tc | output | 1 | Terminal-count pulse on the last accepted step |

## Verification
The bench builds the block with its default parameters: 8-bit page, 16-bit offset and count, and `MODE_SEL`=0. With this setting the `wide_mode` pin chooses the width at every load, so byte and word transfers, and changes of the pin in the middle of a transfer, are all exercised in one build. Directed loads place the offset next to 0x0000 and 0xFFFF in both directions, use odd pages in word mode, use a count of zero, and overlap a load with a step. Random loads use counts of up to 31, so many terminal-count events and ignored steps after completion fall within the run.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;
  // Transfer width selection for the generator.
  localparam int MODE_FROM_PIN = 0;
  localparam int MODE_BYTE_ONLY = 1;
  localparam int MODE_WORD_ONLY = 2;

  localparam logic [1:0] BE_BOTH = 2'b11;
  localparam logic [1:0] BE_LOW  = 2'b01;
  localparam logic [1:0] BE_HIGH = 2'b10;

  // Resolve the effective width from the parameter and the pin.
  function automatic logic pick_wide(input int sel, input logic pin);
    if (sel == MODE_BYTE_ONLY) return 1'b0;
    if (sel == MODE_WORD_ONLY) return 1'b1;
    return pin;
  endfunction
endpackage

// File: rtl/dma_pg_ofs.sv
// Offset counter: wraps inside its width, never produces a carry out.
module dma_pg_ofs #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFS_W-1:0] ld_val,
  input  logic             adv,
  input  logic             dec,
  output logic [OFS_W-1:0] q
);
  localparam logic [OFS_W-1:0] ONE = {{(OFS_W-1){1'b0}}, 1'b1};

  logic [OFS_W-1:0] nxt;

  always_comb begin
    nxt = dec ? (q - ONE) : (q + ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= ld_val;
    else if (adv)  q <= nxt;
  end
endmodule

// File: rtl/dma_pg_cnt.sv
// Remaining-count register with arm state and terminal detection.
module dma_pg_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             adv,
  output logic [CNT_W-1:0] q,
  output logic             armed,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic at_zero;

  assign at_zero = (q == '0);
  assign last    = adv & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      armed <= 1'b0;
    end else if (load) begin
      q     <= ld_val;
      armed <= 1'b1;
    end else if (adv) begin
      q <= q - ONE;
      if (at_zero) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_pg_map.sv
// Forms the physical address and lane enables from page and offset.
module dma_pg_map #(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16,
  localparam int PHYS_W = PAGE_W + OFS_W
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              wide,
  output logic [PHYS_W-1:0] phys,
  output logic [1:0]        be
);
  import dma_pg_pkg::*;

  logic [PHYS_W-1:0] phys_byte;
  logic [PHYS_W-1:0] phys_word;

  // Byte: page over offset. Word: page without its low bit, offset
  // scaled by two, lowest bit fixed at zero.
  assign phys_byte = {page, ofs};
  assign phys_word = {page[PAGE_W-1:1], ofs, 1'b0};

  always_comb begin
    if (wide) begin
      phys = phys_word;
      be   = BE_BOTH;
    end else begin
      phys = phys_byte;
      be   = ofs[0] ? BE_HIGH : BE_LOW;
    end
  end
endmodule

// File: rtl/dma_pg_gen.sv
// Top level of the paged address and count generator.
module dma_pg_gen #(
  parameter int PAGE_W   = 8,
  parameter int OFS_W    = 16,
  parameter int CNT_W    = 16,
  parameter int MODE_SEL = 0,
  localparam int PHYS_W  = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic [OFS_W-1:0]  ld_addr,
  input  logic [CNT_W-1:0]  ld_count,
  input  logic              wide_mode,
  input  logic              dec,
  input  logic              step,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [1:0]        byte_en,
  output logic [OFS_W-1:0]  cur_addr,
  output logic [CNT_W-1:0]  cur_count,
  output logic              tc
);
  import dma_pg_pkg::*;

  logic [PAGE_W-1:0] page_q;
  logic              wide_q;
  logic              armed;
  logic              adv;

  // A step is taken only while armed and not overridden by a load.
  assign adv = step & armed & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      wide_q <= 1'b0;
    end else if (load) begin
      page_q <= ld_page;
      wide_q <= pick_wide(MODE_SEL, wide_mode);
    end
  end

  dma_pg_ofs #(.OFS_W(OFS_W)) u_ofs (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .ld_val (ld_addr),
    .adv    (adv),
    .dec    (dec),
    .q      (cur_addr)
  );

  dma_pg_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .ld_val (ld_count),
    .adv    (adv),
    .q      (cur_count),
    .armed  (armed),
    .last   (tc)
  );

  dma_pg_map #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_map (
    .page (page_q),
    .ofs  (cur_addr),
    .wide (wide_q),
    .phys (phys_addr),
    .be   (byte_en)
  );
endmodule

// File: rtl/dma_pg_gen_chk.sv
module dma_pg_gen_chk #(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16,
  parameter int CNT_W  = 16,
  localparam int PHYS_W = PAGE_W + OFS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic [CNT_W-1:0]  ld_count,
  input logic [PAGE_W-1:0] ld_page,
  input logic              dec,
  input logic              step,
  input logic              armed,
  input logic              wide_q,
  input logic [PHYS_W-1:0] phys_addr,
  input logic [1:0]        byte_en,
  input logic [OFS_W-1:0]  cur_addr,
  input logic [CNT_W-1:0]  cur_count,
  input logic              tc
);
  a_r6_tc_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (step && !load && cur_count == '0));

  a_r7_idle_ignores_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !load) |=> ($stable(cur_addr) && $stable(cur_count)));

  a_r4_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && step && !load && !dec) |=> (cur_addr == $past(cur_addr) + 1'b1));

  a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && step && !load) |=> (cur_count == $past(cur_count) - 1'b1));

  a_r8_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_count == $past(ld_count) && phys_addr[PHYS_W-1:PHYS_W-PAGE_W+1] == $past(ld_page[PAGE_W-1:1])));

  a_r3_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(phys_addr[PHYS_W-1:PHYS_W-PAGE_W+1]));

  a_r9_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    wide_q ? (byte_en == 2'b11 && !phys_addr[0]) : $onehot(byte_en));
endmodule

bind dma_pg_gen dma_pg_gen_chk #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load      (load),
  .ld_count  (ld_count),
  .ld_page   (ld_page),
  .dec       (dec),
  .step      (step),
  .armed     (armed),
  .wide_q    (wide_q),
  .phys_addr (phys_addr),
  .byte_en   (byte_en),
  .cur_addr  (cur_addr),
  .cur_count (cur_count),
  .tc        (tc)
);

// File: tb/dma_pg_gen_bench.sv
`timescale 1ns/100ps
module dma_pg_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [7:0]  ld_page = '0;
  logic [15:0] ld_addr = '0;
  logic [15:0] ld_count = '0;
  logic        wide_mode = 1'b0;
  logic        dec = 1'b0;
  logic        step = 1'b0;
  logic [23:0] phys_addr;
  logic [1:0]  byte_en;
  logic [15:0] cur_addr;
  logic [15:0] cur_count;
  logic        tc;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Bench model of the working state.
  logic [7:0]  m_page = '0;
  logic [15:0] m_addr = '0;
  logic [15:0] m_cnt = '0;
  logic        m_word = 1'b0;
  logic        m_armed = 1'b0;

  always #2.5 clk = ~clk;

  dma_pg_gen u_dma_pg_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_page(ld_page), .ld_addr(ld_addr),
    .ld_count(ld_count), .wide_mode(wide_mode), .dec(dec), .step(step),
    .phys_addr(phys_addr), .byte_en(byte_en), .cur_addr(cur_addr),
    .cur_count(cur_count), .tc(tc)
  );

  function automatic logic [23:0] exp_phys(logic [7:0] pg, logic [15:0] a, logic w);
    return w ? {pg[7:1], a, 1'b0} : {pg, a};
  endfunction

  function automatic logic [1:0] exp_be(logic [15:0] a, logic w);
    return w ? 2'b11 : (a[0] ? 2'b10 : 2'b01);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, compare settled outputs,
  // then advance the model across the rising edge.
  task automatic cyc(input logic ld, input logic [7:0] pg, input logic [15:0] ad,
                     input logic [15:0] ct, input logic wm, input logic st, input logic dc);
    @(negedge clk);
    load = ld; ld_page = pg; ld_addr = ad; ld_count = ct;
    wide_mode = wm; step = st; dec = dc;
    #1;
    chk(m_word ? "R2 phys" : "R1 phys", phys_addr, exp_phys(m_page, m_addr, m_word));
    chk("R9 byte_en", byte_en, exp_be(m_addr, m_word));
    chk("R6 tc", tc, m_armed && st && !ld && m_cnt == 16'h0);
    chk("R4 cur_addr", cur_addr, m_addr);
    chk("R5 cur_count", cur_count, m_cnt);
    @(posedge clk);
    if (ld) begin
      m_page = pg; m_addr = ad; m_cnt = ct; m_word = wm; m_armed = 1'b1;
    end else if (m_armed && st) begin
      m_addr = dc ? m_addr - 16'h1 : m_addr + 16'h1;
      if (m_cnt == 16'h0) m_armed = 1'b0;
      m_cnt = m_cnt - 16'h1;
    end
  endtask

  task automatic idle(input logic st);
    cyc(1'b0, 8'h00, 16'h0, 16'h0, $urandom_range(0, 1), st, $urandom_range(0, 1));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11 phys", phys_addr, 24'h0);
    chk("R11 count", cur_count, 16'h0);
    chk("R11 tc", tc, 1'b0);
    chk("R11 byte_en", byte_en, 2'b01);
    rst_n = 1'b1;
    idle(1'b1);  // R11: disarmed after reset, step ignored
    chk("R11 addr after step", cur_addr, 16'h0);

    // R3: increment wrap, byte mode
    cyc(1'b1, 8'h3c, 16'hfffe, 16'h0003, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
    #1 chk("R3 wrap up addr", cur_addr, 16'h0000);
    chk("R3 wrap up page", phys_addr[23:16], 8'h3c);

    // R3: decrement wrap, word mode on odd page (R2)
    cyc(1'b1, 8'h57, 16'h0001, 16'h0002, 1'b1, 1'b0, 1'b1);
    cyc(1'b0, 0, 0, 0, 1'b1, 1'b1, 1'b1);
    cyc(1'b0, 0, 0, 0, 1'b1, 1'b1, 1'b1);
    #1 chk("R3 wrap down addr", cur_addr, 16'hffff);
    chk("R2 odd page dropped", phys_addr, {7'h2b, 16'hffff, 1'b0});

    // R5/R6/R7: count zero gives one transfer, then ignored
    cyc(1'b1, 8'h10, 16'h0100, 16'h0000, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
    #1 chk("R5 count after last", cur_count, 16'hffff);
    cyc(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
    #1 chk("R7 addr held", cur_addr, 16'h0101);
    chk("R7 tc low", tc, 1'b0);

    // R8: load with step in the same cycle; load wins
    cyc(1'b1, 8'h22, 16'h4000, 16'h0005, 1'b0, 1'b1, 1'b0);
    #1 chk("R8 load wins", cur_addr, 16'h4000);
    chk("R8 count", cur_count, 16'h0005);

    // R10: width latched at load, pin toggled mid-transfer
    cyc(1'b1, 8'h81, 16'h0010, 16'h0004, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
    #1 chk("R10 word held", byte_en, 2'b11);

    // Random loads and step patterns.
    for (int t = 0; t < 60; t++) begin
      cyc(1'b1, 8'($urandom), 16'($urandom), 16'($urandom_range(0, 31)),
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      for (int k = 0; k < 45; k++) idle($urandom_range(0, 3) != 0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule